// File: doc/BRIEF.md
# Network Board Control and Parity Error Capture

This block is the host-facing control and status logic of a network interface board. A single 16-bit control/status word lets software hold the board in reset, switch the transceiver from loopback onto the medium, and pulse a channel-attention line to the network controller. The same word enables two interrupt sources, selects the auxiliary memory bus and the RAM size, and reports the controller interrupt, a parity error flag and four strapped high RAM address bits.

When board memory reports a parity error, the block records the failing 20-bit address, the error source and the failing byte lane. It keeps this record, ignoring further errors, until software writes an acknowledge. Software reads the upper address bits and the error details from a parity control word, and the low 16 address bits from a separate word. The interrupt request to the host combines the controller interrupt and the parity error, each gated by its own enable.

Register select codes on `bus_addr`: 0 is the control/status word, 1 is the parity control word, 2 is the low failing-address word, and 3 reads as zero. Writes take effect on the rising clock edge and reads are combinational.

Top module: `nic_board_ctrl`

## Requirements
- R1: After `rst_n` is low, `board_rst_o`, `on_air_o`, `attn_o`, `irq_o`, `aux_bus_en_o` and `ram256_o` are 0, and the control/status word reads only the strap value in bits 3:0 (plus bit 8 from `ctl_irq_in`).
- R2: A control/status write with bit 15 clear stores bit 14 (on-air, `on_air_o`), bit 13 (attention, `attn_o`), bit 12 (controller interrupt enable), bit 11 (parity interrupt enable), bit 5 (`aux_bus_en_o`) and bit 4 (`ram256_o`), and these read back at the same positions.
- R3: A control/status write with bit 15 set drives `board_rst_o` high, clears bits 14 to 11 whatever was written, and clears the parity error flag; bits 5 and 4 take the written values.
- R4: In the control/status word, bit 9 shows the parity error flag, bit 8 shows `ctl_irq_in` and bits 3:0 show `hi_addr_strap`, none of them writable; bits 10, 7 and 6 read 0.
- R5: With the flag clear and board reset not asserted, a `par_evt` pulse sets the flag (status bit 9) and latches address bits 19:16 into parity control bits 3:0, `par_evt_src` into bit 7, `par_evt_lane` into bit 6, and address bits 15:0 into the low address word.
- R6: While the flag is set, further `par_evt` pulses change none of the latched fields.
- R7: Writing the parity control word with bit 8 set clears the flag and leaves the latched fields readable; a write with bit 8 clear has no effect.
- R8: `irq_o` is high exactly when (`ctl_irq_in` and the controller enable) or (the flag and the parity enable).
- R9: While `board_rst_o` is high, `par_evt` pulses are ignored and the flag stays clear.
- R10: An acknowledge and an event in the same cycle: if the flag was clear the event is latched and the flag ends set; if the flag was set the event is dropped and the flag ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| ctl_irq_in | input | 1 | Interrupt from the network controller |
| hi_addr_strap | input | 4 | RAM address bits 19:16 reported in status |
| par_evt | input | 1 | Parity error event, one cycle |
| par_evt_addr | input | 20 | Failing memory address |
| par_evt_src | input | 1 | Error source indicator |
| par_evt_lane | input | 1 | Failing byte half |
| board_rst_o | output | 1 | Board reset |
| on_air_o | output | 1 | Out of loopback, onto the medium |
| attn_o | output | 1 | Channel attention to the controller |
| aux_bus_en_o | output | 1 | Auxiliary memory bus enable |
| ram256_o | output | 1 | 256 Kbit RAM select |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives a second parity event onto a held error and checks that the address, source and lane still read as the first one; a design that overwrote the record would show the later address. It writes the parity control word without the acknowledge bit and checks that the flag stays, and it lands an acknowledge and an event in the same cycle both with the flag set and clear, where a wrong priority would either lose a fresh error or keep a stale one. It asserts board reset with all control bits written high and with an error pending, expecting on-air, attention, both enables and the flag to drop, and sends an event during reset that must not be latched.

// File: rtl/nic_board_ctrl.sv
module nic_board_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        ctl_irq_in,
  input  logic [3:0]  hi_addr_strap,
  input  logic        par_evt,
  input  logic [19:0] par_evt_addr,
  input  logic        par_evt_src,
  input  logic        par_evt_lane,
  output logic        board_rst_o,
  output logic        on_air_o,
  output logic        attn_o,
  output logic        aux_bus_en_o,
  output logic        ram256_o,
  output logic        irq_o
);
  logic        rst_q, air_q, attn_q, cie_q, pie_q, aux_q, k256_q;
  logic        flag_q, src_q, lane_q;
  logic [19:0] cap_q;

  logic csr_wr, ack, take, hold;
  logic unused_wbits;

  assign csr_wr = bus_wr && (bus_addr == 2'd0);
  assign ack    = bus_wr && (bus_addr == 2'd1) && bus_wdata[8];
  assign hold   = csr_wr && bus_wdata[15];
  assign take   = par_evt && !flag_q && !rst_q;
  assign unused_wbits = ^{bus_wdata[10:9], bus_wdata[7:6], bus_wdata[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      air_q  <= 1'b0;
      attn_q <= 1'b0;
      cie_q  <= 1'b0;
      pie_q  <= 1'b0;
      aux_q  <= 1'b0;
      k256_q <= 1'b0;
      flag_q <= 1'b0;
      src_q  <= 1'b0;
      lane_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      if (csr_wr) begin
        rst_q  <= bus_wdata[15];
        air_q  <= bus_wdata[14] & ~bus_wdata[15];
        attn_q <= bus_wdata[13] & ~bus_wdata[15];
        cie_q  <= bus_wdata[12] & ~bus_wdata[15];
        pie_q  <= bus_wdata[11] & ~bus_wdata[15];
        aux_q  <= bus_wdata[5];
        k256_q <= bus_wdata[4];
      end
      if (ack) flag_q <= 1'b0;
      if (hold) begin
        flag_q <= 1'b0;
      end else if (take) begin
        flag_q <= 1'b1;
        src_q  <= par_evt_src;
        lane_q <= par_evt_lane;
        cap_q  <= par_evt_addr;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {rst_q, air_q, attn_q, cie_q, pie_q, 1'b0, flag_q, ctl_irq_in,
                            2'b00, aux_q, k256_q, hi_addr_strap};
      2'd1:    bus_rdata = {8'h00, src_q, lane_q, 2'b00, cap_q[19:16]};
      2'd2:    bus_rdata = cap_q[15:0];
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign board_rst_o  = rst_q;
  assign on_air_o     = air_q;
  assign attn_o       = attn_q;
  assign aux_bus_en_o = aux_q;
  assign ram256_o     = k256_q;
  assign irq_o        = (ctl_irq_in & cie_q) | (flag_q & pie_q);
endmodule

// File: rtl/nic_board_ctrl_chk.sv
module nic_board_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        par_evt,
  input logic        board_rst_o,
  input logic        on_air_o,
  input logic        attn_o,
  input logic        irq_o,
  input logic        flag,
  input logic [19:0] cap
);
  logic ack_w;
  assign ack_w = bus_wr && (bus_addr == 2'd1) && bus_wdata[8];

  assert_reset_quiets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_o |-> (!irq_o && !attn_o && !on_air_o));

  assert_no_capture_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_o |-> !flag);

  assert_first_event_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_evt && !flag && !board_rst_o && !(bus_wr && bus_addr == 2'd0 && bus_wdata[15])) |=> flag);

  assert_record_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(cap));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w && flag) |=> !flag);
endmodule

bind nic_board_ctrl nic_board_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .par_evt(par_evt), .board_rst_o(board_rst_o),
  .on_air_o(on_air_o), .attn_o(attn_o), .irq_o(irq_o),
  .flag(flag_q), .cap(cap_q)
);

// File: tb/nic_board_ctrl_test.sv
module nic_board_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        ctl_irq_in = 1'b0;
  logic [3:0]  hi_addr_strap = 4'h5;
  logic        par_evt = 1'b0;
  logic [19:0] par_evt_addr = '0;
  logic        par_evt_src = 1'b0;
  logic        par_evt_lane = 1'b0;
  logic        board_rst_o, on_air_o, attn_o, aux_bus_en_o, ram256_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nic_board_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_irq_in(ctl_irq_in),
    .hi_addr_strap(hi_addr_strap), .par_evt(par_evt), .par_evt_addr(par_evt_addr),
    .par_evt_src(par_evt_src), .par_evt_lane(par_evt_lane),
    .board_rst_o(board_rst_o), .on_air_o(on_air_o), .attn_o(attn_o),
    .aux_bus_en_o(aux_bus_en_o), .ram256_o(ram256_o), .irq_o(irq_o)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic evt(input logic [19:0] a, input logic s, input logic l);
    @(negedge clk);
    par_evt = 1'b1; par_evt_addr = a; par_evt_src = s; par_evt_lane = l;
    @(negedge clk);
    par_evt = 1'b0;
  endtask

  task automatic ack_and_evt(input logic [19:0] a, input logic s, input logic l);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0100;
    par_evt = 1'b1; par_evt_addr = a; par_evt_src = s; par_evt_lane = l;
    @(negedge clk);
    bus_wr = 1'b0; par_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v);
    check("R1 status after reset", v, 16'h0005);
    check("R1 outputs after reset",
          {10'b0, board_rst_o, on_air_o, attn_o, aux_bus_en_o, ram256_o, irq_o}, 16'h0);
  endtask

  task automatic t_ctrl_bits();
    logic [15:0] v;
    wr(2'd0, 16'h7830);
    rd(2'd0, v);
    check("R2 control readback", v, 16'h7835);
    check("R2 control outputs", {12'b0, on_air_o, attn_o, aux_bus_en_o, ram256_o}, 16'h000F);
    wr(2'd0, 16'h0000);
    check("R2 attention released", {15'b0, attn_o}, 16'h0);
  endtask

  task automatic t_readonly();
    logic [15:0] v;
    wr(2'd0, 16'h7FFF);
    rd(2'd0, v);
    check("R4 read-only bits", v, 16'h7835);
    ctl_irq_in = 1'b1;
    rd(2'd0, v);
    check("R4 controller irq visible", v, 16'h7935);
    check("R8 irq from controller", {15'b0, irq_o}, 16'h1);
    ctl_irq_in = 1'b0;
  endtask

  task automatic t_board_reset();
    logic [15:0] v;
    wr(2'd0, 16'hF830);
    rd(2'd0, v);
    check("R3 reset clears control", v, 16'h8035);
    check("R3 board reset out", {13'b0, board_rst_o, on_air_o, attn_o}, 16'h0004);
    ctl_irq_in = 1'b1;
    #1 check("R8 irq gated in reset", {15'b0, irq_o}, 16'h0);
    ctl_irq_in = 1'b0;
    evt(20'hFFFFF, 1'b1, 1'b1);
    rd(2'd0, v);
    check("R9 event ignored in reset", v, 16'h8035);
    rd(2'd1, v);
    check("R9 no record in reset", v, 16'h0000);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(2'd0, 16'h0800);
    evt(20'hA1234, 1'b1, 1'b0);
    rd(2'd0, v);
    check("R5 flag set", v, 16'h0A05);
    rd(2'd1, v);
    check("R5 source/lane/high addr", v, 16'h008A);
    rd(2'd2, v);
    check("R5 low addr", v, 16'h1234);
    check("R8 irq from parity", {15'b0, irq_o}, 16'h1);
    evt(20'h5BEEF, 1'b0, 1'b1);
    rd(2'd1, v);
    check("R6 second event ignored hi", v, 16'h008A);
    rd(2'd2, v);
    check("R6 second event ignored lo", v, 16'h1234);
    wr(2'd1, 16'h0000);
    rd(2'd0, v);
    check("R7 write without ack keeps flag", v, 16'h0A05);
    wr(2'd1, 16'h0100);
    rd(2'd0, v);
    check("R7 ack clears flag", v, 16'h0805);
    check("R8 irq drops after ack", {15'b0, irq_o}, 16'h0);
    rd(2'd1, v);
    check("R7 fields kept after ack", v, 16'h008A);
    evt(20'h5BEEF, 1'b0, 1'b1);
    rd(2'd1, v);
    check("R5 new capture hi", v, 16'h0045);
    rd(2'd2, v);
    check("R5 new capture lo", v, 16'hBEEF);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    ack_and_evt(20'h70777, 1'b1, 1'b0);
    rd(2'd0, v);
    check("R10 flag set: event dropped, flag cleared", v, 16'h0805);
    rd(2'd2, v);
    check("R10 flag set: record unchanged", v, 16'hBEEF);
    ack_and_evt(20'h30001, 1'b1, 1'b1);
    rd(2'd0, v);
    check("R10 flag clear: event latched", v, 16'h0A05);
    rd(2'd1, v);
    check("R10 latched hi", v, 16'h00C3);
    rd(2'd2, v);
    check("R10 latched lo", v, 16'h0001);
    wr(2'd0, 16'h8000);
    rd(2'd0, v);
    check("R3 reset clears pending flag", v, 16'h8005);
    wr(2'd0, 16'h0000);
    rd(2'd0, v);
    check("R3 flag stays clear after reset", v, 16'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_bits();
    t_readonly();
    t_board_reset();
    t_capture();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule